// File: doc/BRIEF.md
# First-Word-Fall-Through Output Stage

This block sits between the read port of an ordinary synchronous FIFO and a downstream consumer, so that the consumer sees first-word-fall-through behaviour. A word written into an empty FIFO is moved into a local output register without any request from the consumer. Every later word needs an explicit read. An active-low output-ready flag marks a valid word on the data output. An active-low input-ready flag reports whether the combined store can accept more data.

The inner FIFO must show its head word combinationally on `src_data` and pop it on the edge where `src_rd` is high. It also reports its fill level on `src_count`. The output register is one extra slot, so the store holds `DEPTH + 1` words in total. The almost-empty, half-full, almost-full and input-ready thresholds all count that extra slot. The offsets for the partial flags are fixed parameters.

A new word is fetched only when the inner FIFO has been non-empty for a run of edges. This models the settling of a buffered empty indication, and it sets the fall-through latency to three read-clock edges.

Top module: `fwft_out_stage`

## Requirements
- R1: A word written into a completely empty store, after at least two idle edges, drives `out_rdy_n` low and appears on `dout` after the third rising clock edge following the write edge. No read enable is needed.
- R2: `src_rd` is high, and the head word is loaded into the output register on that edge, exactly when all three of these hold: `src_count` is non-zero now, `src_count` was non-zero at each of the two previous edges, and the output slot is either empty or being read on this edge.
- R3: While `out_rdy_n` is low and `rd_en_n` is high, `dout` and `out_rdy_n` keep their values.
- R4: An edge with `rd_en_n` low and `out_rdy_n` low that fetches no replacement word drives `out_rdy_n` high after that edge.
- R5: While `out_rdy_n` is high, `rd_en_n` low has no effect: `dout` keeps the last value it held (zero after reset).
- R6: When a read coincides with a fetch, `out_rdy_n` stays low across the edge, with no bubble.
- R7: `in_rdy_n` is high exactly when the total held (`src_count` plus one if `out_rdy_n` is low) sampled two edges earlier equals `DEPTH + 1`.
- R8: While `rst_n` is low: `out_rdy_n` = 1, `in_rdy_n` = 0, `dout` = 0, `src_rd` = 0.
- R9: `pae_n` is low exactly when the current total is at most `AE_OFS + 1`.
- R10: `hf_n` is low exactly when the current total is at least `DEPTH/2 + 2`.
- R11: `paf_n` is low exactly when the current total is at least `DEPTH + 1 - AF_OFS`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_count | input | $clog2(DEPTH+1) | Words held in the inner FIFO |
| src_data | input | DW | Head word of the inner FIFO |
| src_rd | output | 1 | Pops the inner FIFO head on this edge |
| rd_en_n | input | 1 | Active-low read request from consumer |
| dout | output | DW | Output register |
| out_rdy_n | output | 1 | Low when `dout` holds a valid word |
| in_rdy_n | output | 1 | High when the store is full (two-edge delay) |
| pae_n | output | 1 | Active-low almost-empty |
| hf_n | output | 1 | Active-low half-full |
| paf_n | output | 1 | Active-low almost-full |

## Verification
The output register and `out_rdy_n` change one edge after a fetch or a read is decided. `src_rd` and the three partial flags are combinational and settle within the same cycle as their inputs. `in_rdy_n` reflects the total from two edges earlier, and a first word reaches `dout` three edges after its write. The bench keeps a behavioural model that advances once per rising edge, holds short histories of non-emptiness and fullness for the delayed results, and compares every output at the falling edge, after all registers on the path have updated. `src_rd` is compared against the model's fetch decision once the new read enable has settled.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

  // Threshold arithmetic for the combined store (inner FIFO plus output slot).
  function automatic logic store_full(int total, int depth);
    return total == depth + 1;
  endfunction

  function automatic logic near_empty(int total, int ofs);
    return total <= ofs + 1;
  endfunction

  function automatic logic past_half(int total, int depth);
    return total >= depth / 2 + 2;
  endfunction

  function automatic logic near_full(int total, int depth, int ofs);
    return total >= depth + 1 - ofs;
  endfunction

endpackage

// File: rtl/fwft_delay_line.sv
module fwft_delay_line #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) sr[0] <= 1'b0;
          else        sr[0] <= d;
        end
      end else begin : g_tail
        always_ff @(posedge clk) begin
          if (!rst_n) sr[i] <= 1'b0;
          else        sr[i] <= sr[i-1];
        end
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/fwft_out_slot.sv
module fwft_out_slot #(
  parameter int DW       = 18,
  parameter int CW       = 9,
  parameter int FALL_LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] src_count,
  input  logic [DW-1:0] src_data,
  input  logic          rd_en_n,
  output logic          fetch,
  output logic          consume,
  output logic          valid,
  output logic [DW-1:0] dout
);
  localparam int HL = FALL_LAT - 1;

  logic          nonempty;
  logic [HL-1:0] hist;
  logic          settled;

  assign nonempty = (src_count != '0);

  // Non-empty history: a fetch needs an unbroken run of non-empty edges.
  generate
    for (genvar i = 0; i < HL; i++) begin : g_hist
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) hist[0] <= 1'b0;
          else        hist[0] <= nonempty;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) hist[i] <= 1'b0;
          else        hist[i] <= hist[i-1];
        end
      end
    end
  endgenerate

  assign settled = nonempty & (&hist);
  assign consume = valid & ~rd_en_n;
  assign fetch   = settled & (~valid | consume);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (fetch) begin
      valid <= 1'b1;
      dout  <= src_data;
    end else if (consume) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fwft_level_flags.sv
module fwft_level_flags
  import fwft_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int AE_OFS = 127,
  parameter int AF_OFS = 127,
  parameter int TW     = 9
) (
  input  logic [TW-1:0] total,
  output logic          full_now,
  output logic          pae_n,
  output logic          hf_n,
  output logic          paf_n
);
  int tot_i;

  always_comb begin
    tot_i    = int'(total);
    full_now = store_full(tot_i, DEPTH);
    pae_n    = ~near_empty(tot_i, AE_OFS);
    hf_n     = ~past_half(tot_i, DEPTH);
    paf_n    = ~near_full(tot_i, DEPTH, AF_OFS);
  end
endmodule

// File: rtl/fwft_out_stage.sv
module fwft_out_stage #(
  parameter int DW       = 18,
  parameter int DEPTH    = 256,
  parameter int AE_OFS   = 127,
  parameter int AF_OFS   = 127,
  parameter int FALL_LAT = 3,
  parameter int IR_LAT   = 2,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int TW      = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] src_count,
  input  logic [DW-1:0] src_data,
  output logic          src_rd,
  input  logic          rd_en_n,
  output logic [DW-1:0] dout,
  output logic          out_rdy_n,
  output logic          in_rdy_n,
  output logic          pae_n,
  output logic          hf_n,
  output logic          paf_n
);
  // Named internal events, visible to the bound checker.
  logic          fetch;
  logic          consume;
  logic          slot_valid;
  logic          full_now;
  logic [TW-1:0] total;

  fwft_out_slot #(.DW(DW), .CW(CW), .FALL_LAT(FALL_LAT)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_count(src_count),
    .src_data (src_data),
    .rd_en_n  (rd_en_n),
    .fetch    (fetch),
    .consume  (consume),
    .valid    (slot_valid),
    .dout     (dout)
  );

  assign total = TW'(src_count) + TW'(slot_valid);

  fwft_level_flags #(.DEPTH(DEPTH), .AE_OFS(AE_OFS), .AF_OFS(AF_OFS), .TW(TW)) u_lvl (
    .total   (total),
    .full_now(full_now),
    .pae_n   (pae_n),
    .hf_n    (hf_n),
    .paf_n   (paf_n)
  );

  fwft_delay_line #(.STAGES(IR_LAT)) u_ir (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (full_now),
    .q    (in_rdy_n)
  );

  assign src_rd    = fetch;
  assign out_rdy_n = ~slot_valid;
endmodule

// File: rtl/fwft_out_chk.sv
module fwft_out_chk #(
  parameter int DW    = 18,
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en_n,
  input logic          src_rd,
  input logic [CW-1:0] src_count,
  input logic [DW-1:0] dout,
  input logic          out_rdy_n,
  input logic          in_rdy_n
);
  logic chk_full;
  assign chk_full = (int'(src_count) + (out_rdy_n ? 0 : 1)) == DEPTH + 1;

  // R2
  no_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |-> (src_count != '0));

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_rdy_n && rd_en_n) |=> (!out_rdy_n && $stable(dout)));

  // R4
  last_read_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_rdy_n && !rd_en_n && !src_rd) |=> out_rdy_n);

  // R5
  empty_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_rdy_n && !src_rd) |=> $stable(dout));

  // R6
  no_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_rdy_n && !rd_en_n && src_rd) |=> !out_rdy_n);

  // R7
  full_flag_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rdy_n == $past(chk_full, 2));
endmodule

bind fwft_out_stage fwft_out_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_fwft_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en_n  (rd_en_n),
  .src_rd   (src_rd),
  .src_count(src_count),
  .dout     (dout),
  .out_rdy_n(out_rdy_n),
  .in_rdy_n (in_rdy_n)
);

// File: tb/test_fwft_out_stage.sv
module test_fwft_out_stage;
  localparam int DW = 18;
  localparam int D  = 8;
  localparam int AE = 2;
  localparam int AF = 2;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] src_count = '0;
  logic [DW-1:0] src_data = '0;
  logic          src_rd;
  logic          rd_en_n = 1'b1;
  logic [DW-1:0] dout;
  logic          out_rdy_n, in_rdy_n, pae_n, hf_n, paf_n;

  always #2.5 clk = ~clk;

  fwft_out_stage #(.DW(DW), .DEPTH(D), .AE_OFS(AE), .AF_OFS(AF)) i_fwft_out_stage (
    .clk(clk), .rst_n(rst_n), .src_count(src_count), .src_data(src_data),
    .src_rd(src_rd), .rd_en_n(rd_en_n), .dout(dout), .out_rdy_n(out_rdy_n),
    .in_rdy_n(in_rdy_n), .pae_n(pae_n), .hf_n(hf_n), .paf_n(paf_n)
  );

  int vectors = 0;
  int errs = 0;
  int q[$];
  int mdout = 0;
  bit mvalid = 1'b0;
  bit h1 = 1'b0, h2 = 1'b0;
  bit f1 = 1'b0, f2 = 1'b0;
  int seq = 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_src();
    src_count = CW'(q.size());
    src_data  = (q.size() != 0) ? DW'(q[0]) : '0;
  endtask

  // One clock of stimulus with full comparison against the reference model.
  task automatic step(bit wr, bit rdn);
    int  tot;
    bit  ne, fetch, wr_ok;
    @(negedge clk);
    tot = q.size() + (mvalid ? 1 : 0);
    chk("R1/R4/R6 out_rdy_n", out_rdy_n, !mvalid);
    chk("R3/R5 dout", dout, mdout);
    chk("R7 in_rdy_n", in_rdy_n, f2);
    chk("R9 pae_n", pae_n, !(tot <= AE + 1));
    chk("R10 hf_n", hf_n, !(tot >= D / 2 + 2));
    chk("R11 paf_n", paf_n, !(tot >= D + 1 - AF));
    rd_en_n = rdn;
    #1;
    ne    = (q.size() != 0);
    fetch = ne && h1 && h2 && (!mvalid || !rdn);
    chk("R2 src_rd", src_rd, fetch);
    wr_ok = wr && (q.size() < D);
    @(posedge clk);
    #1;
    f2 = f1; f1 = (tot == D + 1);
    h2 = h1; h1 = ne;
    if (fetch) begin
      mdout  = q.pop_front();
      mvalid = 1'b1;
    end else if (mvalid && !rdn) begin
      mvalid = 1'b0;
    end
    if (wr_ok) begin
      q.push_back(seq);
      seq = (seq % 200000) + 1;
    end
    drive_src();
  endtask

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    int n;
    int low_run;
    drive_src();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    chk("R8 out_rdy_n", out_rdy_n, 1);
    chk("R8 in_rdy_n", in_rdy_n, 0);
    chk("R8 dout", dout, 0);
    chk("R8 src_rd", src_rd, 0);
    rst_n = 1'b1;

    // R5: reads against an empty store
    repeat (3) step(1'b0, 1'b0);

    // R1: fall-through latency of a single word
    step(1'b1, 1'b1);
    n = 0;
    while (out_rdy_n && n < 10) begin
      step(1'b0, 1'b1);
      n++;
    end
    chk("R1 fall-through edges", n, 3);
    chk("R1 first word", dout, 1);

    // Fill to capacity with no reads (R7, R10, R11)
    repeat (14) step(1'b1, 1'b1);
    chk("R7 capacity", q.size() + (mvalid ? 1 : 0), D + 1);
    chk("R7 in_rdy_n full", in_rdy_n, 1);

    // R3: hold while full, with writes blocked upstream
    repeat (4) step(1'b1, 1'b1);

    // R6: continuous drain, out_rdy_n must stay low while words remain
    low_run = 0;
    for (int i = 0; i < D; i++) begin
      step(1'b0, 1'b0);
      if (!out_rdy_n) low_run++;
    end
    chk("R6 no bubble during drain", low_run, D);

    // R4: final word read leaves the store empty
    repeat (4) step(1'b0, 1'b0);
    chk("R4 empty after last read", out_rdy_n, 1);

    // Mixed traffic
    for (int i = 0; i < 3000; i++) begin
      step(1'(($urandom % 3) != 0), 1'(($urandom % 3) == 0));
    end
    for (int i = 0; i < 1000; i++) begin
      step(1'(($urandom % 2) != 0), 1'(($urandom % 2) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule